// File: doc/BRIEF.md
# Serial-to-Wishbone Register Access Bridge

This block lets an external controller reach memory-mapped registers through a four-wire serial port. The controller drives chip select, serial clock and the data-in line. The block decodes each frame and runs read or write cycles on a 32-bit pipelined Wishbone bus, where it acts as the bus master. Read data goes back to the controller on the data-out line.

All four serial pins are sampled by the system clock, so the block has a single clock domain. A frame opens with one command byte: bit 7 selects write (1) or read (0), and bits 3:0 are the byte enables. Three address bytes follow. After that come any number of 32-bit data words. Every field is sent most significant bit first. The address is a 24-bit byte address that steps by four for each word of a burst. The upper eight Wishbone address bits come from a parameter.

Reads are launched as soon as the address is complete. The block keeps one word prefetched, so a burst can stream without gaps. Raising chip select ends the frame and drops any partly received word.

Top module: `spi_wb_bridge`

## Requirements
- R1: The serial clock polarity and phase are parameters. Incoming bits are sampled on the rising serial clock edge when polarity equals phase, and on the falling edge otherwise. The outgoing bit changes on the opposite edge. The controller can read a valid bit at each of its sampling edges.
- R2: Command byte encoding: bit 7 = 1 requests writes and 0 requests reads. Bits 3:0 are the byte enables driven on every access of the frame. Bits 6:4 have no effect.
- R3: In a write frame, each complete 32-bit data word produces exactly one Wishbone write. That write carries the word, the byte enables and the current address.
- R4: In a read frame, a Wishbone read of the header address is issued once the 24th address bit arrives. Its data is shifted out MSB first, starting with the first data bit of the frame.
- R5: Within a burst, each further word uses the previous address plus 4. In read bursts the next word is fetched ahead, so consecutive words stream without gaps.
- R6: Wishbone address bits 31:24 always equal the ADDR_TOP parameter. The 24-bit field wraps modulo 2^24.
- R7: Deasserting chip select discards a partial data word and resets the frame decoder. The next frame decodes from a fresh command byte. The data-out line is held low while the block is deselected.
- R8: Wishbone handshake: strobe is only high inside a cycle. While the request is stalled, strobe, address, data, write enable and byte enables hold their values. The cycle ends the clock after acknowledge.
- R9: After reset, cycle, strobe and the data-out line are low.
- R10: At most one Wishbone access is outstanding: strobe drops after acceptance, and no new request starts before acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 32 | Byte address |
| wb_dat_o | output | 32 | Write data |
| wb_sel | output | 4 | Byte enables |
| wb_stall | input | 1 | Slave cannot take the request this cycle |
| wb_ack | input | 1 | Access complete |
| wb_dat_i | input | 32 | Read data |

## Verification
Each serial clock edge reaches the decoder two synchroniser stages plus one register later. The data-out bit therefore settles three system clocks after a shift edge. The bench runs with a half period of 12 system clocks and samples the line only at its own sampling edge, well after that settling point. A Wishbone request appears one clock after a word or header completes, and the bench slave acknowledges one clock after acceptance. The bench reads its transaction log only after chip select has been high for four half periods, by which time every access of the frame has finished. The data-out line is low no later than four clocks after chip select rises, and the bench checks it after a longer wait.

// File: rtl/spiwb_pkg.sv
package spiwb_pkg;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam int SW = DW / 8;
  localparam int TW = DW - AW;

  typedef struct packed {
    logic          we;
    logic [SW-1:0] sel;
    logic [AW-1:0] adr;
    logic [DW-1:0] dat;
  } bus_req_t;
endpackage

// File: rtl/spiwb_pin_sync.sv
module spiwb_pin_sync #(
  parameter int STAGES = 2,
  parameter bit CPOL   = 1'b0,
  parameter bit CPHA   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic smp_stb,
  output logic shf_stb,
  output logic mosi_s,
  output logic cs_act
);
  // order inside each stage: {cs_n, sck, mosi}
  localparam logic [2:0] RST_V = {1'b1, CPOL, 1'b0};

  logic [2:0] stg_q [STAGES];
  logic       sck_d_q;
  logic       rise, fall;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_V;
        else        stg_q[i] <= {cs_n_i, sck_i, mosi_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_V;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= CPOL;
    else        sck_d_q <= stg_q[STAGES-1][1];
  end

  assign rise   = stg_q[STAGES-1][1] & ~sck_d_q;
  assign fall   = ~stg_q[STAGES-1][1] & sck_d_q;
  assign mosi_s = stg_q[STAGES-1][0];
  assign cs_act = ~stg_q[STAGES-1][2];

  if (CPOL == CPHA) begin : g_smp_rise
    assign smp_stb = rise;
    assign shf_stb = fall;
  end else begin : g_smp_fall
    assign smp_stb = fall;
    assign shf_stb = rise;
  end
endmodule

// File: rtl/spiwb_frame.sv
module spiwb_frame
  import spiwb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic          shf_stb,
  input  logic          mosi_bit,
  input  logic          cs_act,
  input  logic          rsp_vld,
  input  logic [DW-1:0] rsp_dat,
  output bus_req_t      req,
  output logic          req_vld,
  input  logic          req_take,
  output logic          miso
);
  localparam int HDR_BITS = 8 + AW;
  localparam int CW       = $clog2(HDR_BITS + 1);
  localparam int BW       = $clog2(DW);

  logic [CW-1:0] hdr_q, hdr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          we_q, we_d;
  logic [SW-1:0] sel_q, sel_d;
  logic [AW-1:0] adr_q, adr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          wr_pend_q, wr_pend_d;
  logic          rd_pend_q, rd_pend_d;
  logic          rd_wait_q, rd_wait_d;
  logic [DW-1:0] rbuf_q, rbuf_d;
  logic          rbuf_vld_q, rbuf_vld_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          miso_q, miso_d;
  logic          in_data;

  assign in_data = (hdr_q == CW'(HDR_BITS));

  always_comb begin
    hdr_d      = hdr_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    we_d       = we_q;
    sel_d      = sel_q;
    adr_d      = adr_q;
    wdat_d     = wdat_q;
    wr_pend_d  = wr_pend_q;
    rd_pend_d  = rd_pend_q;
    rd_wait_d  = rd_wait_q;
    rbuf_d     = rbuf_q;
    rbuf_vld_d = rbuf_vld_q;
    tx_d       = tx_q;
    miso_d     = miso_q;

    // bus side: request accepted by the master, then read data returned
    if (req_take) begin
      if (wr_pend_q) begin
        wr_pend_d = 1'b0;
      end else begin
        rd_pend_d = 1'b0;
        rd_wait_d = 1'b1;
      end
      adr_d = adr_q + AW'(SW);
    end
    if (rsp_vld && rd_wait_q) begin
      rbuf_d     = rsp_dat;
      rbuf_vld_d = 1'b1;
      rd_wait_d  = 1'b0;
    end

    if (cs_act) begin
      if (smp_stb) begin
        sh_d = {sh_q[DW-2:0], mosi_bit};
        if (!in_data) begin
          hdr_d = hdr_q + 1'b1;
          if (hdr_q == CW'(7)) begin
            we_d  = sh_q[6];
            sel_d = {sh_q[SW-2:0], mosi_bit};
          end
          if (hdr_q == CW'(HDR_BITS - 1)) begin
            adr_d     = {sh_q[AW-2:0], mosi_bit};
            rd_pend_d = ~we_q;
          end
        end else begin
          bit_d = bit_q + 1'b1;
          if (bit_q == BW'(DW - 1) && we_q) begin
            wdat_d    = {sh_q[DW-2:0], mosi_bit};
            wr_pend_d = 1'b1;
          end
        end
      end
      if (shf_stb) begin
        if (in_data && !we_q) begin
          if (bit_q == '0) begin
            // word boundary: take the prefetched word, ask for the next one
            miso_d     = rbuf_vld_q & rbuf_q[DW-1];
            tx_d       = {rbuf_q[DW-2:0], 1'b0};
            rbuf_vld_d = 1'b0;
            rd_pend_d  = 1'b1;
          end else begin
            miso_d = tx_q[DW-1];
            tx_d   = {tx_q[DW-2:0], 1'b0};
          end
        end else begin
          miso_d = 1'b0;
        end
      end
    end else begin
      hdr_d      = '0;
      bit_d      = '0;
      rd_pend_d  = 1'b0;
      rd_wait_d  = 1'b0;
      rbuf_vld_d = 1'b0;
      miso_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      we_q       <= 1'b0;
      sel_q      <= '0;
      adr_q      <= '0;
      wdat_q     <= '0;
      wr_pend_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_wait_q  <= 1'b0;
      rbuf_q     <= '0;
      rbuf_vld_q <= 1'b0;
      tx_q       <= '0;
      miso_q     <= 1'b0;
    end else begin
      hdr_q      <= hdr_d;
      bit_q      <= bit_d;
      sh_q       <= sh_d;
      we_q       <= we_d;
      sel_q      <= sel_d;
      adr_q      <= adr_d;
      wdat_q     <= wdat_d;
      wr_pend_q  <= wr_pend_d;
      rd_pend_q  <= rd_pend_d;
      rd_wait_q  <= rd_wait_d;
      rbuf_q     <= rbuf_d;
      rbuf_vld_q <= rbuf_vld_d;
      tx_q       <= tx_d;
      miso_q     <= miso_d;
    end
  end

  assign req_vld = wr_pend_q | rd_pend_q;
  assign req.we  = wr_pend_q;
  assign req.sel = sel_q;
  assign req.adr = adr_q;
  assign req.dat = wdat_q;
  assign miso    = miso_q;
endmodule

// File: rtl/spiwb_wb_master.sv
module spiwb_wb_master
  import spiwb_pkg::*;
#(
  parameter logic [TW-1:0] ADDR_TOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_req_t      req,
  input  logic          req_vld,
  output logic          req_take,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [DW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  output logic [SW-1:0] wb_sel,
  input  logic          wb_stall,
  input  logic          wb_ack,
  input  logic [DW-1:0] wb_dat_i,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_dat
);
  logic     cyc_q, cyc_d;
  logic     stb_q, stb_d;
  bus_req_t lat_q, lat_d;

  assign req_take = req_vld & ~cyc_q;

  always_comb begin
    cyc_d = cyc_q;
    stb_d = stb_q;
    lat_d = lat_q;
    if (req_take) begin
      cyc_d = 1'b1;
      stb_d = 1'b1;
      lat_d = req;
    end else begin
      if (stb_q && !wb_stall) stb_d = 1'b0;
      if (cyc_q && wb_ack)    cyc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
      lat_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      stb_q <= stb_d;
      lat_q <= lat_d;
    end
  end

  assign wb_cyc   = cyc_q;
  assign wb_stb   = stb_q;
  assign wb_we    = lat_q.we;
  assign wb_adr   = {ADDR_TOP, lat_q.adr};
  assign wb_dat_o = lat_q.dat;
  assign wb_sel   = lat_q.sel;
  assign rsp_vld  = cyc_q & wb_ack & ~lat_q.we;
  assign rsp_dat  = wb_dat_i;
endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge
  import spiwb_pkg::*;
#(
  parameter bit            CPOL        = 1'b0,
  parameter bit            CPHA        = 1'b0,
  parameter int            SYNC_STAGES = 2,
  parameter logic [TW-1:0] ADDR_TOP    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [DW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  output logic [SW-1:0] wb_sel,
  input  logic          wb_stall,
  input  logic          wb_ack,
  input  logic [DW-1:0] wb_dat_i
);
  logic          smp_stb, shf_stb, mosi_s, cs_act;
  bus_req_t      req;
  logic          req_vld, req_take;
  logic          rsp_vld;
  logic [DW-1:0] rsp_dat;

  spiwb_pin_sync #(
    .STAGES (SYNC_STAGES),
    .CPOL   (CPOL),
    .CPHA   (CPHA)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_i   (spi_sck),
    .mosi_i  (spi_mosi),
    .cs_n_i  (spi_cs_n),
    .smp_stb (smp_stb),
    .shf_stb (shf_stb),
    .mosi_s  (mosi_s),
    .cs_act  (cs_act)
  );

  spiwb_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .shf_stb  (shf_stb),
    .mosi_bit (mosi_s),
    .cs_act   (cs_act),
    .rsp_vld  (rsp_vld),
    .rsp_dat  (rsp_dat),
    .req      (req),
    .req_vld  (req_vld),
    .req_take (req_take),
    .miso     (spi_miso)
  );

  spiwb_wb_master #(
    .ADDR_TOP (ADDR_TOP)
  ) u_wbm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_vld  (req_vld),
    .req_take (req_take),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_sel   (wb_sel),
    .wb_stall (wb_stall),
    .wb_ack   (wb_ack),
    .wb_dat_i (wb_dat_i),
    .rsp_vld  (rsp_vld),
    .rsp_dat  (rsp_dat)
  );
endmodule

// File: rtl/spiwb_bridge_chk.sv
module spiwb_bridge_chk #(
  parameter int STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_miso,
  input logic        wb_cyc,
  input logic        wb_stb,
  input logic        wb_we,
  input logic [31:0] wb_adr,
  input logic [31:0] wb_dat_o,
  input logic [3:0]  wb_sel,
  input logic        wb_stall,
  input logic        wb_ack
);
  logic [3:0] cs_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cs_hi_q <= '0;
    else if (!spi_cs_n)        cs_hi_q <= '0;
    else if (cs_hi_q != 4'hF)  cs_hi_q <= cs_hi_q + 4'd1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && wb_stall |=> wb_stb && $stable(wb_adr) && $stable(wb_we)
                           && $stable(wb_sel) && $stable(wb_dat_o));

  // R8
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc);

  // R8
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && wb_ack |=> !wb_cyc);

  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && !wb_stall |=> !wb_stb);

  // R7
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cs_hi_q) >= STAGES + 2) |-> !spi_miso);
endmodule

bind spi_wb_bridge spiwb_bridge_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .wb_cyc   (wb_cyc),
  .wb_stb   (wb_stb),
  .wb_we    (wb_we),
  .wb_adr   (wb_adr),
  .wb_dat_o (wb_dat_o),
  .wb_sel   (wb_sel),
  .wb_stall (wb_stall),
  .wb_ack   (wb_ack)
);

// File: tb/spi_wb_bridge_tb.sv
module spi_wb_bridge_tb;
  localparam bit       BCPOL = 1'b1;
  localparam bit       BCPHA = 1'b1;
  localparam logic [7:0] TOP = 8'hA7;
  localparam int       H     = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic        wb_cyc, wb_stb, wb_we, wb_stall, wb_ack;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i;
  logic [3:0]  wb_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  spi_wb_bridge #(
    .CPOL (BCPOL), .CPHA (BCPHA), .SYNC_STAGES (2), .ADDR_TOP (TOP)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .spi_cs_n (spi_cs_n), .spi_sck (spi_sck), .spi_mosi (spi_mosi), .spi_miso (spi_miso),
    .wb_cyc (wb_cyc), .wb_stb (wb_stb), .wb_we (wb_we), .wb_adr (wb_adr),
    .wb_dat_o (wb_dat_o), .wb_sel (wb_sel), .wb_stall (wb_stall),
    .wb_ack (wb_ack), .wb_dat_i (wb_dat_i)
  );

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[31:16]};
  endfunction

  // bus slave model with periodic stall and a transaction log
  logic [2:0]  scnt;
  logic        acc;
  logic        lg_we  [256];
  logic [31:0] lg_adr [256];
  logic [31:0] lg_dat [256];
  logic [3:0]  lg_sel [256];
  int          lg_n;
  int          out_n;
  logic        viol;

  assign wb_stall = (scnt == 3'd3);
  assign acc      = wb_cyc & wb_stb & ~wb_stall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0; wb_ack <= 1'b0; wb_dat_i <= '0; lg_n <= 0; out_n <= 0; viol <= 1'b0;
    end else begin
      scnt   <= (scnt == 3'd4) ? 3'd0 : scnt + 3'd1;
      wb_ack <= acc;
      out_n  <= out_n + (acc ? 1 : 0) - (wb_ack ? 1 : 0);
      if (acc && out_n != 0) viol <= 1'b1;
      if (acc) begin
        wb_dat_i           <= rd_val(wb_adr);
        lg_we [lg_n % 256] <= wb_we;
        lg_adr[lg_n % 256] <= wb_adr;
        lg_dat[lg_n % 256] <= wb_dat_o;
        lg_sel[lg_n % 256] <= wb_sel;
        lg_n               <= lg_n + 1;
      end
    end
  end

  logic [31:0] tx_words [8];
  logic [31:0] rx_words [8];

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] val, input int nb, output logic [31:0] got);
    got = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (!BCPHA) begin
        spi_mosi = val[i];
        repeat (H) @(negedge clk);
        spi_sck = ~BCPOL;
        got = {got[30:0], spi_miso};
        repeat (H) @(negedge clk);
        spi_sck = BCPOL;
      end else begin
        spi_sck  = ~BCPOL;
        spi_mosi = val[i];
        repeat (H) @(negedge clk);
        spi_sck = BCPOL;
        got = {got[30:0], spi_miso};
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic run_frame(input logic [7:0] cmd, input logic [23:0] adr, input int nw, input int cut);
    logic [31:0] junk;
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    xfer({24'h0, cmd}, 8, junk);
    xfer({8'h0, adr}, 24, junk);
    for (int w = 0; w < nw; w++) xfer(tx_words[w], 32, rx_words[w]);
    if (cut > 0) xfer(tx_words[nw], cut, junk);
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  // {we, sel[3:0], adr[23:0], data[31:0]}
  localparam logic [60:0] VEC [8] = '{
    {1'b1, 4'hF, 24'h000010, 32'hDEADBEEF},
    {1'b1, 4'h3, 24'h123454, 32'h0BADF00D},
    {1'b0, 4'hF, 24'h000020, 32'h0},
    {1'b1, 4'h8, 24'hFFFFFC, 32'h01020304},
    {1'b0, 4'h5, 24'hABCDE8, 32'h0},
    {1'b1, 4'h0, 24'h000000, 32'hFFFFFFFF},
    {1'b0, 4'hF, 24'hFFFFFC, 32'h0},
    {1'b0, 4'hC, 24'h7FFFF0, 32'h0}
  };

  initial begin
    int base;
    logic [31:0] junk;
    logic [60:0] v;
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = BCPOL; spi_mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset cyc", {63'h0, wb_cyc}, 64'h0);
    chk("R9 reset stb", {63'h0, wb_stb}, 64'h0);
    chk("R9 reset miso", {63'h0, spi_miso}, 64'h0);

    for (int i = 0; i < 8; i++) begin
      v    = VEC[i];
      base = lg_n;
      tx_words[0] = v[31:0];
      run_frame({v[60], 3'(i), v[59:56]}, v[55:32], 1, 0);
      if (v[60]) begin
        chk("R3 write count", 64'(lg_n - base), 64'd1);
        chk("R2 R3 we", {63'h0, lg_we[base % 256]}, 64'h1);
        chk("R3 R6 write adr", {32'h0, lg_adr[base % 256]}, {32'h0, TOP, v[55:32]});
        chk("R2 sel", {60'h0, lg_sel[base % 256]}, {60'h0, v[59:56]});
        chk("R3 write data", {32'h0, lg_dat[base % 256]}, {32'h0, v[31:0]});
      end else begin
        chk("R1 R4 read data", {32'h0, rx_words[0]}, {32'h0, rd_val({TOP, v[55:32]})});
        chk("R4 read adr", {32'h0, lg_adr[base % 256]}, {32'h0, TOP, v[55:32]});
        chk("R2 R4 read we", {63'h0, lg_we[base % 256]}, 64'h0);
      end
      chk("R7 miso low deselected", {63'h0, spi_miso}, 64'h0);
    end

    // burst write across the 24-bit wrap
    base = lg_n;
    tx_words[0] = 32'h11112222; tx_words[1] = 32'h33334444; tx_words[2] = 32'h55556666;
    run_frame(8'h8F, 24'hFFFFF8, 3, 0);
    chk("R5 R8 burst write count", 64'(lg_n - base), 64'd3);
    chk("R5 burst adr0", {32'h0, lg_adr[base % 256]}, {32'h0, TOP, 24'hFFFFF8});
    chk("R5 burst adr1", {32'h0, lg_adr[(base + 1) % 256]}, {32'h0, TOP, 24'hFFFFFC});
    chk("R6 burst adr wrap", {32'h0, lg_adr[(base + 2) % 256]}, {32'h0, TOP, 24'h000000});
    chk("R5 burst data2", {32'h0, lg_dat[(base + 2) % 256]}, 64'h55556666);

    // burst read, four words
    for (int w = 0; w < 4; w++) tx_words[w] = '0;
    run_frame(8'h0F, 24'h000100, 4, 0);
    for (int w = 0; w < 4; w++)
      chk("R5 burst read data", {32'h0, rx_words[w]}, {32'h0, rd_val({TOP, 24'h000100 + 24'(4 * w)})});

    // read burst across the wrap
    run_frame(8'h0F, 24'hFFFFFC, 2, 0);
    chk("R6 wrap read w0", {32'h0, rx_words[0]}, {32'h0, rd_val({TOP, 24'hFFFFFC})});
    chk("R6 wrap read w1", {32'h0, rx_words[1]}, {32'h0, rd_val({TOP, 24'h000000})});

    // partial data word dropped on deselect
    base = lg_n;
    tx_words[0] = 32'hCAFE0001; tx_words[1] = 32'hCAFE0002;
    run_frame(8'h8F, 24'h000200, 1, 16);
    chk("R7 partial word dropped", 64'(lg_n - base), 64'd1);
    chk("R7 full word kept", {32'h0, lg_dat[base % 256]}, 64'hCAFE0001);

    // header cut short, next frame decodes fresh
    base = lg_n;
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    xfer(32'h0000008F, 8, junk);
    xfer(32'h00000ABC, 12, junk);
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
    chk("R7 header abort no access", 64'(lg_n - base), 64'd0);
    tx_words[0] = 32'h33333333;
    run_frame(8'h81, 24'h000300, 1, 0);
    chk("R7 reframe count", 64'(lg_n - base), 64'd1);
    chk("R7 reframe adr", {32'h0, lg_adr[base % 256]}, {32'h0, TOP, 24'h000300});
    chk("R7 reframe sel", {60'h0, lg_sel[base % 256]}, 64'h1);

    chk("R10 one outstanding access", {63'h0, viol}, 64'h0);
    chk("R8 bus idle at end", {62'h0, wb_cyc, wb_stb}, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule